// File: doc/BRIEF.md
# Decade Ripple-Rule Counter

This block counts count-enable pulses in decimal, presenting one BCD digit whose bits weigh 1, 2, 4 and 8. Instead of comparing a binary count against nine and forcing it back to zero, each bit follows its own toggle rule, the way a chain of negative-edge stages would. The lowest bit flips on every counted pulse. The weight-2 bit flips when the lowest bit falls, but only while the weight-8 bit is low. The weight-4 bit flips when the weight-2 bit falls. The weight-8 bit is set when the lowest bit falls with the weight-2 and weight-4 bits both high, and is cleared when the lowest bit next falls. The return from nine to zero comes out of these rules.

All four bits share one clock. A "fall" of a lower bit is worked out inside the clock cycle from its present value and its computed next value, so every bit updates on the same edge. An active-low asynchronous clear forces the digit to its reset value at once, and its release is passed through a synchronizer. A one-cycle carry pulse marks each nine-to-zero wrap, so a following digit can use it as its count enable. A parameter sets the value loaded by the clear. It is normally zero, and it can place the counter in a non-decimal code to show that the counter recovers from one.

Top module: `decade_counter`

## Requirements
- R1: While `rst_n` is low, `bcd` equals the parameter `INIT_VALUE` (default 0) and `carry` is 0.
- R2: A clock edge with `cnt_en` low leaves `bcd` unchanged and gives `carry` = 0 in the next cycle.
- R3: Each counted edge (`cnt_en` high) inverts `bcd[0]`.
- R4: On a counted edge where `bcd[0]` is 1, `bcd[1]` becomes the inverse of its old value if `bcd[3]` is 0, and becomes 0 if `bcd[3]` is 1. On every other counted edge `bcd[1]` keeps its value.
- R5: `bcd[2]` inverts on exactly those counted edges where `bcd[1]` goes from 1 to 0.
- R6: On a counted edge where `bcd[0]` is 1, `bcd[3]` becomes 1 only if `bcd[1]`, `bcd[2]` are 1 and `bcd[3]` is 0, and becomes 0 otherwise (7 goes to 8, 9 goes to 0). With `bcd[0]` = 0 it keeps its value.
- R7: Starting from 0, counted edges step `bcd` through 0,1,...,9 and back to 0.
- R8: `carry` is 1 for exactly the one cycle after a counted edge that takes `bcd` from 9 to 0, and 0 in every other cycle.
- R9: From a non-decimal code, counted edges follow 10→11→4, 12→13→4 and 14→15→0, so `bcd` is 9 or less after at most two counts.
- R10: After `rst_n` rises, the first two clock edges do not count even with `cnt_en` high. The third edge is the first that can count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all bits update on its rising edge |
| rst_n | input | 1 | Active-low asynchronous clear, release synchronized |
| cnt_en | input | 1 | Count enable; each rising edge with it high is one count |
| bcd | output | 4 | Current digit, bit i has weight 2^i |
| carry | output | 1 | One-cycle pulse following the 9-to-0 wrap |

## Verification
The hardest case to reach is the recovery from codes 10 to 15, because the clear loads zero and the toggle rules never leave the decimal range. The bench therefore builds extra copies of the counter whose `INIT_VALUE` is 10, 12 or 14. Random count enables then drive these copies along the same paths through the upper codes, and a reference next-state function predicts each path. Directed stretches of continuous counting cover the 7→8 set and the 9→0 clear of the top bit, together with the carry that follows the wrap.

// File: rtl/decade_counter_pkg.sv
package decade_counter_pkg;
  localparam int DIGIT_W  = 4;
  localparam int LAST_DEC = 9;

  typedef logic [DIGIT_W-1:0] digit_t;

  typedef enum logic [1:0] {
    BIT_W1 = 2'd0,
    BIT_W2 = 2'd1,
    BIT_W4 = 2'd2,
    BIT_W8 = 2'd3
  } bit_pos_e;

  function automatic logic is_decimal(input digit_t d);
    return d <= digit_t'(LAST_DEC);
  endfunction
endpackage

// File: rtl/decade_reset_sync.sv
module decade_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/decade_toggle_logic.sv
module decade_toggle_logic
  import decade_counter_pkg::*;
(
  input  logic   clk,
  input  logic   srst_n,
  input  logic   step,
  input  digit_t cur,
  output digit_t nxt,
  output logic   wrap
);
  logic fall_w1;
  logic fall_w2;
  logic set8;

  always_comb begin
    nxt = cur;
    // weight 1: flips on every counted edge
    nxt[BIT_W1] = step ? ~cur[BIT_W1] : cur[BIT_W1];
    fall_w1 = step & cur[BIT_W1] & ~nxt[BIT_W1];
    // weight 2: driven by the weight-1 fall, held low while weight 8 is set
    if (fall_w1) begin
      nxt[BIT_W2] = cur[BIT_W8] ? 1'b0 : ~cur[BIT_W2];
    end
    fall_w2 = cur[BIT_W2] & ~nxt[BIT_W2];
    // weight 4: driven by the weight-2 fall
    if (fall_w2) begin
      nxt[BIT_W4] = ~cur[BIT_W4];
    end
    // weight 8: set-when-2-and-4, otherwise clear, on the weight-1 fall
    set8 = cur[BIT_W2] & cur[BIT_W4] & ~cur[BIT_W8];
    if (fall_w1) begin
      nxt[BIT_W8] = set8;
    end
    wrap = step & (cur == digit_t'(LAST_DEC)) & (nxt == '0);
  end

  // R4: with weight 8 high, a weight-1 fall leaves weight 2 at zero
  assert_w2_inhibit_R4: assert property (@(posedge clk) disable iff (!srst_n)
    (step && cur[BIT_W1] && cur[BIT_W8]) |=> !cur[BIT_W2]);

  // R5: weight 4 only changes when weight 2 dropped on the same edge
  assert_w4_follows_w2_R5: assert property (@(posedge clk) disable iff (!srst_n)
    (cur[BIT_W2] && !step) |=> $stable(cur[BIT_W4]));

  // R9: an odd unused code always lands back in the decimal range
  assert_recover_R9: assert property (@(posedge clk) disable iff (!srst_n)
    (step && cur[BIT_W1] && !is_decimal(cur)) |=> is_decimal(cur));
endmodule

// File: rtl/decade_counter.sv
module decade_counter
  import decade_counter_pkg::*;
#(
  parameter logic [3:0] INIT_VALUE  = 4'd0,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cnt_en,
  output logic [3:0] bcd,
  output logic       carry
);
  logic   srst_n;
  digit_t digit_q;
  digit_t digit_d;
  logic   wrap;
  logic   carry_q;
  logic   carry_d;

  decade_reset_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  decade_toggle_logic u_toggle (
    .clk    (clk),
    .srst_n (srst_n),
    .step   (cnt_en),
    .cur    (digit_q),
    .nxt    (digit_d),
    .wrap   (wrap)
  );

  always_comb begin
    carry_d = wrap;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      digit_q <= digit_t'(INIT_VALUE);
      carry_q <= 1'b0;
    end else begin
      carry_q <= carry_d;
      if (cnt_en) begin
        digit_q <= digit_d;
      end
    end
  end

  assign bcd   = digit_q;
  assign carry = carry_q;

  // R2: no count enable, no change and no carry
  assert_hold_R2: assert property (@(posedge clk) disable iff (!srst_n)
    !cnt_en |=> ($stable(bcd) && !carry));

  // R3: lowest bit inverts on each counted edge
  assert_w1_toggle_R3: assert property (@(posedge clk) disable iff (!srst_n)
    cnt_en |=> (bcd[0] != $past(bcd[0])));

  // R6: seven steps to eight
  assert_set8_R6: assert property (@(posedge clk) disable iff (!srst_n)
    (cnt_en && bcd == 4'd7) |=> (bcd == 4'd8));

  // R8: wrap from nine gives zero plus one carry cycle
  assert_wrap_carry_R8: assert property (@(posedge clk) disable iff (!srst_n)
    (cnt_en && bcd == 4'd9) |=> (carry && bcd == 4'd0));

  // R8: carry never lasts two cycles
  assert_carry_single_R8: assert property (@(posedge clk) disable iff (!srst_n)
    carry |=> !carry);
endmodule

// File: tb/decade_counter_bench.sv
`timescale 1ns/1ps
module decade_counter_bench;
  logic clk;
  logic rst_n;
  logic cnt_en;
  logic [3:0] bcd [4];
  logic       carry [4];
  logic [3:0] exp_bcd [4];
  logic       exp_carry [4];
  int checks;
  int errors;
  bit done;

  localparam logic [3:0] INITS [4] = '{4'd0, 4'd10, 4'd12, 4'd14};

  initial clk = 1'b0;
  always #2 clk = ~clk;

  decade_counter #(.INIT_VALUE(4'd0)) u_decade_counter (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .bcd(bcd[0]), .carry(carry[0]));
  decade_counter #(.INIT_VALUE(4'd10)) u_unused_10 (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .bcd(bcd[1]), .carry(carry[1]));
  decade_counter #(.INIT_VALUE(4'd12)) u_unused_12 (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .bcd(bcd[2]), .carry(carry[2]));
  decade_counter #(.INIT_VALUE(4'd14)) u_unused_14 (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .bcd(bcd[3]), .carry(carry[3]));

  function automatic logic [3:0] ref_next(input logic [3:0] v);
    case (v)
      4'd9:  return 4'd0;
      4'd10: return 4'd11;
      4'd11: return 4'd4;
      4'd12: return 4'd13;
      4'd13: return 4'd4;
      4'd14: return 4'd15;
      4'd15: return 4'd0;
      default: return v + 4'd1;
    endcase
  endfunction

  function automatic string bit_tag(input logic [3:0] got, input logic [3:0] want,
                                    input int inst);
    logic [3:0] diff;
    diff = got ^ want;
    if (inst != 0)    return "R9";
    if (diff[0])      return "R3";
    if (diff[1])      return "R4";
    if (diff[2])      return "R5";
    return "R6";
  endfunction

  task automatic check_val(input string tag, input int inst,
                           input logic [3:0] got, input logic [3:0] want);
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s inst %0d: actual %0d expected %0d at %0t", tag, inst, got, want, $time);
    end
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < 4; i++) begin
      check_val((tag == "") ? bit_tag(bcd[i], exp_bcd[i], i) : tag, i, bcd[i], exp_bcd[i]);
      check_val((tag == "") ? "R8" : tag, i, {3'b0, carry[i]}, {3'b0, exp_carry[i]});
    end
  endtask

  task automatic advance(input logic en);
    cnt_en = en;
    @(posedge clk);
    for (int i = 0; i < 4; i++) begin
      exp_carry[i] = en && (exp_bcd[i] == 4'd9);
      if (en) exp_bcd[i] = ref_next(exp_bcd[i]);
    end
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0;
    errors = 0;
    done = 1'b0;
    void'($urandom(32'd4021));
    rst_n = 1'b0;
    cnt_en = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      exp_bcd[i] = INITS[i];
      exp_carry[i] = 1'b0;
    end
    check_all("R1");

    // R10: release with counting requested; two edges pass without a count
    rst_n = 1'b1;
    cnt_en = 1'b1;
    @(negedge clk);
    check_all("R10");
    @(negedge clk);
    check_all("R10");
    advance(1'b1);
    check_all("R10");

    // R7: long run of continuous counting through several wraps
    for (int c = 0; c < 25; c++) begin
      advance(1'b1);
      check_all("");
    end
    // R9: unused copies are back in range by now
    for (int i = 1; i < 4; i++) check_val("R9", i, {3'b0, bcd[i] <= 4'd9}, 4'd1);

    // R2: idle cycles hold the digit
    for (int c = 0; c < 4; c++) begin
      advance(1'b0);
      check_all("R2");
    end

    // random enables
    for (int c = 0; c < 3000; c++) begin
      advance(logic'($urandom_range(0, 3) != 0));
      check_all("");
    end

    // R9: reload unused codes and count them out again
    rst_n = 1'b0;
    cnt_en = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      exp_bcd[i] = INITS[i];
      exp_carry[i] = 1'b0;
    end
    check_all("R1");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    advance(1'b1);
    check_all("R9");
    advance(1'b1);
    check_all("R9");
    check_val("R9", 1, bcd[1], 4'd4);
    check_val("R9", 2, bcd[2], 4'd4);
    check_val("R9", 3, bcd[3], 4'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule